// File: doc/BRIEF.md
# Single-Channel Strided Memory Copy Engine

This block moves a programmed number of equally sized items from a source region to a destination region over a plain synchronous read/write memory port. One start pulse hands it a configuration: an item width of 8, 16 or 32 bits shared by both sides, a per-side address step, the address of the last item on each side, and the item count. The engine computes every address itself. For item k of N it subtracts (N-1-k) steps from that side's last address. It then moves each item as one read followed by one write.

Each side has its own step. A step of zero pins that side to a single address, such as a peripheral data register. A step larger than the item width spreads the items out, for example bytes placed on word boundaries. A configuration with a misaligned last address, a nonzero step narrower than the item, or an unknown width code is refused before any memory access. The refusal is reported on an error flag. A finished transfer gives a one-cycle done pulse, and the engine then returns to idle.

Top module: `dma_xfer_engine`

## Requirements
- R1: `cfg_size` codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. Every read and write of a transfer carries the latched code on `rd_size`/`wr_size`. Code 3 is refused: `err` goes high and no access is made.
- R2: Step codes, chosen separately for source and destination, are 0 = none, 1 = 1 byte, 2 = 2 bytes and 3 = 4 bytes. A step wider than the item width is legal.
- R3: For N items, item k (k = 0..N-1) is read from `src_end - (N-1-k)*src_step` and written to `dst_end - (N-1-k)*dst_step`, modulo 2^ADDR_W.
- R4: A side whose step is none uses its end pointer as the address of every access.
- R5: `cfg_last_idx` holds N-1 in a CNT_W-bit field (10 bits by default), so N ranges from 1 to 1024.
- R6: A start whose nonzero step on either side is smaller than the item width sets `err`. It makes no access and gives no done pulse. An accepted start clears `err`.
- R7: A start whose source or destination end pointer is not a multiple of the item width sets `err` and makes no access.
- R8: Each item is one read, held until `rd_valid`, and then one write, held with stable data until `wr_ack`. The next read starts only after the write is acknowledged. The write data carries the read data's low item bytes, with the upper bits zero.
- R9: `done` is high for exactly one cycle, in the cycle after the last write is acknowledged. `busy` is low in that same cycle.
- R10: A start pulse while `busy` is high is ignored and does not change the running transfer.
- R11: After reset, `busy`, `done`, `err`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; the configuration is sampled with it |
| cfg_size | input | 2 | Item width code |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_src_end | input | ADDR_W | Address of the last source item |
| cfg_dst_end | input | ADDR_W | Address of the last destination item |
| cfg_last_idx | input | CNT_W | Item count minus one |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was refused |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read width code |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data, item in the low bytes |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Write data, item in the low bytes |
| wr_ack | input | 1 | Write accepted |

## Verification
The bench builds the engine with ADDR_W = 16 and keeps the default CNT_W = 10. With these values a full 1024-item run fits in a few thousand cycles, and the address offsets of up to 4092 bytes stay inside a sparse byte memory held by the bench. Read data carries junk in the bytes above the item, which shows whether the upper write bits are cleared. A configurable acknowledge stall holds reads and writes open over several cycles, which exercises the hold rules. A start placed in the middle of a run checks that the ignored configuration leaves no trace in memory.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_BAD = 2'd3
  } xsize_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_1    = 2'd1,
    STEP_2    = 2'd2,
    STEP_4    = 2'd3
  } step_e;

  function automatic logic [2:0] size_bytes(xsize_e sz);
    case (sz)
      SZ_8:    return 3'd1;
      SZ_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] step_bytes(step_e st);
    case (st)
      STEP_1:  return 3'd1;
      STEP_2:  return 3'd2;
      STEP_4:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(xsize_e sz);
    case (sz)
      SZ_8:    return 32'h0000_00FF;
      SZ_16:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic step_too_small(step_e st, xsize_e sz);
    return (step_bytes(st) != 3'd0) && (step_bytes(st) < size_bytes(sz));
  endfunction

  function automatic logic low_misaligned(logic [1:0] low, xsize_e sz);
    case (sz)
      SZ_16:   return low[0];
      SZ_32:   return |low;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_xfer_cfg_check.sv
module dma_xfer_cfg_check
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  xsize_e            size,
  input  step_e             src_step,
  input  step_e             dst_step,
  input  logic [ADDR_W-1:0] src_end,
  input  logic [ADDR_W-1:0] dst_end,
  output logic              fault
);

  logic bad_size;
  logic src_short;
  logic dst_short;
  logic src_misal;
  logic dst_misal;

  always_comb begin
    bad_size  = (size == SZ_BAD);
    src_short = step_too_small(src_step, size);
    dst_short = step_too_small(dst_step, size);
    src_misal = low_misaligned(src_end[1:0], size);
    dst_misal = low_misaligned(dst_end[1:0], size);
    fault     = bad_size | src_short | dst_short | src_misal | dst_misal;
  end

endmodule

// File: rtl/dma_xfer_addr_gen.sv
module dma_xfer_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  xsize_e            size,
  input  step_e             step,
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  remain,
  output logic [ADDR_W-1:0] addr
);

  localparam int PROD_W = CNT_W + 3;

  function automatic logic [ADDR_W-1:0] item_addr(
    logic [ADDR_W-1:0] last_addr,
    logic [CNT_W-1:0]  left,
    logic [2:0]        stride
  );
    logic [PROD_W-1:0] back;
    back = {3'b000, left} * {{CNT_W{1'b0}}, stride};
    return last_addr - ADDR_W'(back);
  endfunction

  assign addr = item_addr(end_ptr, remain, step_bytes(step));

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !low_misaligned(addr[1:0], size)) else $error("unaligned access"); // R7

  AST_FIXED_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == STEP_NONE) |-> addr == end_ptr) else $error("fixed side moved"); // R4

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fault,
  input  logic [CNT_W-1:0]  last_idx,
  input  xsize_e            size,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              wr_ack,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_req,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  remain
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

  seq_state_e        state;
  logic [WORD_W-1:0] item_q;
  logic              rd_fire;
  logic              wr_fire;
  logic              last_item;

  assign busy      = (state != ST_IDLE);
  assign rd_req    = (state == ST_READ);
  assign wr_req    = (state == ST_WRITE);
  assign wr_data   = item_q;
  assign rd_fire   = rd_req && rd_valid;
  assign wr_fire   = wr_req && wr_ack;
  assign last_item = (remain == '0);
  assign accept    = (state == ST_IDLE) && start && !fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      item_q <= '0;
      remain <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            err <= fault;
            if (!fault) begin
              remain <= last_idx;
              state  <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rd_fire) begin
            item_q <= rd_data & size_mask(size);
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_fire) begin
            if (last_item) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              remain <= remain - 1'b1;
              state  <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_ack) && !busy)) else $error("done without final ack"); // R9

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)) else $error("read and write together"); // R8

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data))) else $error("write dropped"); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy) else $error("busy with error"); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_fire && last_item)) |=> busy) else $error("run cut short"); // R10

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_size,
  input  logic [1:0]        cfg_src_step,
  input  logic [1:0]        cfg_dst_step,
  input  logic [ADDR_W-1:0] cfg_src_end,
  input  logic [ADDR_W-1:0] cfg_dst_end,
  input  logic [CNT_W-1:0]  cfg_last_idx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [31:0]       wr_data,
  input  logic              wr_ack
);

  localparam int SIDES = 2;

  logic              fault;
  logic              accept;
  logic [CNT_W-1:0]  remain;
  xsize_e            size_q;
  step_e             step_in [SIDES];
  logic [ADDR_W-1:0] end_in  [SIDES];
  step_e             step_q  [SIDES];
  logic [ADDR_W-1:0] end_q   [SIDES];
  logic [ADDR_W-1:0] side_addr [SIDES];

  assign step_in[0] = step_e'(cfg_src_step);
  assign step_in[1] = step_e'(cfg_dst_step);
  assign end_in[0]  = cfg_src_end;
  assign end_in[1]  = cfg_dst_end;

  dma_xfer_cfg_check #(.ADDR_W(ADDR_W)) u_check (
    .size     (xsize_e'(cfg_size)),
    .src_step (step_in[0]),
    .dst_step (step_in[1]),
    .src_end  (cfg_src_end),
    .dst_end  (cfg_dst_end),
    .fault    (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= SZ_8;
    else if (accept) size_q <= xsize_e'(cfg_size);
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_q[s] <= STEP_NONE;
        end_q[s]  <= '0;
      end else if (accept) begin
        step_q[s] <= step_in[s];
        end_q[s]  <= end_in[s];
      end
    end

    dma_xfer_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (busy),
      .size    (size_q),
      .step    (step_q[s]),
      .end_ptr (end_q[s]),
      .remain  (remain),
      .addr    (side_addr[s])
    );
  end

  dma_xfer_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fault    (fault),
    .last_idx (cfg_last_idx),
    .size     (size_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .wr_ack   (wr_ack),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .remain   (remain)
  );

  assign rd_addr = side_addr[0];
  assign wr_addr = side_addr[1];
  assign rd_size = size_q;
  assign wr_size = size_q;

  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (!busy || $stable(rd_size))) else $error("width changed mid-run"); // R1

endmodule

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;

  localparam int AW = 16;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    cfg_size = 2'd0, cfg_src_step = 2'd0, cfg_dst_step = 2'd0;
  logic [AW-1:0] cfg_src_end = '0, cfg_dst_end = '0;
  logic [CW-1:0] cfg_last_idx = '0;
  logic          busy, done, err;
  logic          rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0]    rd_size, wr_size;
  logic          rd_valid = 1'b0;
  logic [31:0]   rd_data = '0;
  logic [31:0]   wr_data;
  logic          wr_ack = 1'b0;

  always #10 clk = ~clk;

  dma_xfer_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_size(cfg_size),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_src_end(cfg_src_end), .cfg_dst_end(cfg_dst_end),
    .cfg_last_idx(cfg_last_idx), .busy(busy), .done(done), .err(err),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall_mod = 1;

  // behavioural reference state
  bit [7:0]    mem [int];
  int unsigned rd_q[$];
  int unsigned wr_q[$];
  bit          m_busy = 0, m_err = 0, m_wphase = 0, exp_done = 0;
  bit          rd_given = 0, ack_given = 0;
  int          m_size = 0;
  int          items_left = 0;
  int unsigned exp_wd = 0;
  int          seen_req = 0, seen_done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic int stepb(int code);
    return (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? 2 : 4;
  endfunction

  function automatic bit [7:0] get_byte(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 13 + 5) & 255);
  endfunction

  function automatic bit legal(int sz, int ss, int ds, int se, int de);
    int w;
    if (sz == 3) return 0;
    w = nbytes(sz);
    if (stepb(ss) != 0 && stepb(ss) < w) return 0;
    if (stepb(ds) != 0 && stepb(ds) < w) return 0;
    if ((se % w) != 0 || (de % w) != 0) return 0;
    return 1;
  endfunction

  always @(negedge clk) begin
    bit old_busy;
    int a;
    int unsigned v;
    cyc++;
    if (cyc > 180000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 180000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (!rst_n) begin
      chk(busy == 0 && done == 0 && err == 0, "R11", "reset busy/done/err", {busy, done, err}, 0);
      chk(rd_req == 0 && wr_req == 0, "R11", "reset requests", {rd_req, wr_req}, 0);
    end else begin
      old_busy = m_busy;
      exp_done = 0;
      if (ack_given) begin
        ack_given = 0;
        if (items_left == 0) begin m_busy = 0; exp_done = 1; end
        else m_wphase = 0;
      end
      if (rd_given) begin rd_given = 0; m_wphase = 1; end
      if (start && !old_busy) begin
        if (!legal(cfg_size, cfg_src_step, cfg_dst_step, cfg_src_end, cfg_dst_end)) begin
          m_err = 1;
        end else begin
          int n, sa, da;
          m_err = 0; m_busy = 1; m_wphase = 0;
          m_size = cfg_size;
          n = int'(cfg_last_idx) + 1;
          items_left = n;
          rd_q.delete(); wr_q.delete();
          sa = (int'(cfg_src_end) - (n - 1) * stepb(cfg_src_step)) & 16'hFFFF;
          da = (int'(cfg_dst_end) - (n - 1) * stepb(cfg_dst_step)) & 16'hFFFF;
          for (int k = 0; k < n; k++) begin
            rd_q.push_back(sa); wr_q.push_back(da);
            sa = (sa + stepb(cfg_src_step)) & 16'hFFFF;
            da = (da + stepb(cfg_dst_step)) & 16'hFFFF;
          end
        end
      end
      if (rd_req || wr_req) seen_req++;
      if (done) seen_done++;
      chk(busy == m_busy, "R9", "busy", busy, m_busy);
      chk(done == exp_done, "R9", "done", done, exp_done);
      chk(err == m_err, "R6", "err", err, m_err);
      chk(rd_req == (m_busy && !m_wphase), "R8", "rd_req", rd_req, m_busy && !m_wphase);
      chk(wr_req == (m_busy && m_wphase), "R8", "wr_req", wr_req, m_busy && m_wphase);
      if (rd_req && rd_q.size() > 0) begin
        chk(rd_addr == rd_q[0], "R3", "rd_addr", rd_addr, rd_q[0]);
        chk(rd_size == m_size, "R1", "rd_size", rd_size, m_size);
      end
      if (wr_req && wr_q.size() > 0) begin
        chk(wr_addr == wr_q[0], "R3", "wr_addr", wr_addr, wr_q[0]);
        chk(wr_data == exp_wd, "R8", "wr_data", wr_data, exp_wd);
        chk(wr_size == m_size, "R1", "wr_size", wr_size, m_size);
      end
    end
    #1;
    rd_valid = 0;
    wr_ack = 0;
    if (rst_n && rd_req && rd_q.size() > 0 && (cyc % stall_mod) == 0) begin
      a = rd_q.pop_front();
      v = 0;
      for (int i = 0; i < nbytes(m_size); i++) v |= int'(get_byte((a + i) & 16'hFFFF)) << (8 * i);
      exp_wd = v;
      rd_data = (m_size == 2) ? v : (v | (32'hDEADBEEF & ~((32'h1 << (8 * nbytes(m_size))) - 1)));
      rd_valid = 1;
      rd_given = 1;
    end
    if (rst_n && wr_req && wr_q.size() > 0 && (cyc % stall_mod) == 0) begin
      a = wr_q.pop_front();
      for (int i = 0; i < nbytes(m_size); i++) mem[(a + i) & 16'hFFFF] = wr_data[8 * i +: 8];
      items_left--;
      wr_ack = 1;
      ack_given = 1;
    end
  end

  task automatic kick(int sz, int ss, int ds, int se, int de, int last);
    @(negedge clk); #2;
    cfg_size = 2'(sz); cfg_src_step = 2'(ss); cfg_dst_step = 2'(ds);
    cfg_src_end = AW'(se); cfg_dst_end = AW'(de); cfg_last_idx = CW'(last);
    start = 1;
    @(negedge clk); #2;
    start = 0;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while ((m_busy || rd_given || ack_given) && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk); @(negedge clk);
    chk(t < 20000, req, "transfer finished", t, 20000);
  endtask

  task automatic run(string req, int sz, int ss, int ds, int se, int de, int last);
    seen_done = 0;
    kick(sz, ss, ds, se, de, last);
    wait_idle(req);
    chk(seen_done == 1, req, "one done pulse", seen_done, 1);
    chk(err == 0, req, "err clear after legal run", err, 0);
  endtask

  task automatic reject(string req, int sz, int ss, int ds, int se, int de);
    seen_req = 0; seen_done = 0;
    kick(sz, ss, ds, se, de, 3);
    repeat (10) @(negedge clk);
    chk(err == 1, req, "err raised", err, 1);
    chk(seen_req == 0, req, "no access on refusal", seen_req, 0);
    chk(seen_done == 0, req, "no done on refusal", seen_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    repeat (2) @(negedge clk);
    // R4: fixed source register, byte data into byte-stepped buffer
    run("R4", 0, 0, 1, 16'h1000, 16'h2003, 3);
    chk(mem[16'h2000] == get_byte(16'h1000), "R4", "fixed source copied", mem[16'h2000], get_byte(16'h1000));
    // R3: half-words both sides
    run("R3", 1, 2, 2, 16'h3006, 16'h4106, 2);
    // R8: words with stalls on read and write
    stall_mod = 3;
    run("R8", 2, 3, 3, 16'h5010, 16'h6010, 4);
    stall_mod = 1;
    // R2: byte data spread on word step
    run("R2", 0, 1, 3, 16'h0805, 16'h0914, 5);
    // R2: half data, word-stepped source, fixed destination
    run("R2", 1, 3, 0, 16'h0A0C, 16'h0B02, 3);
    // R6: step narrower than item
    reject("R6", 1, 1, 2, 16'h1000, 16'h2000);
    reject("R6", 2, 3, 2, 16'h1000, 16'h2000);
    // R7: misaligned end pointers
    reject("R7", 2, 3, 3, 16'h1002, 16'h2000);
    reject("R7", 1, 2, 2, 16'h1000, 16'h2001);
    // R1: unknown width code
    reject("R1", 3, 3, 3, 16'h1000, 16'h2000);
    // R5: single item, then full-length run
    run("R5", 2, 0, 0, 16'hC000, 16'hC100, 0);
    chk(mem[16'hC100] == get_byte(16'hC000), "R5", "single item moved", mem[16'hC100], get_byte(16'hC000));
    run("R5", 0, 0, 1, 16'hD000, 16'h8FFF, 1023);
    chk(mem[16'h8C00] == get_byte(16'hD000), "R5", "first of 1024 placed", mem[16'h8C00], get_byte(16'hD000));
    // R10: start during a run is ignored
    seen_done = 0;
    stall_mod = 2;
    kick(0, 1, 1, 16'h1107, 16'h1207, 7);
    repeat (4) @(negedge clk);
    kick(0, 0, 0, 16'h1300, 16'h7000, 0);
    wait_idle("R10");
    stall_mod = 1;
    chk(!mem.exists(16'h7000), "R10", "ignored config left no write", mem.exists(16'h7000), 0);
    chk(seen_done == 1, "R10", "single done", seen_done, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule